// File: doc/BRIEF.md
# Linked-descriptor XOR and zero-check engine

This block follows a chain of descriptors kept in a word-addressed memory. It has a single read/write port to that memory. The port allows one outstanding request at a time, and each request is answered by one response pulse.

For each descriptor the engine loads these words:
- the link word;
- the control word;
- the fill pattern;
- the length word;
- the destination;
- one to sixteen source addresses.

It then does one of three things. It fills the destination with the pattern. Or it writes the word-wise XOR of the sources to the destination, which is a plain copy when there is one source. Or it XORs the sources only to test whether the result is all zero, and writes nothing to the destination. When a descriptor finishes, the engine can write a status word back into that descriptor's own length word. It pulses an end-of-descriptor event, and an interrupt event when the descriptor asks for one. A zero link ends the chain.

Addresses are word addresses, and data moves in 32-bit words. The length is given in bytes and must be a multiple of 4. Upper address words and the direction field are not used.

The controller has these states:
- IDLE: waits for `start`.
- LINK, CTRL, PAT, LEN, DST: fetch descriptor words 0, 1, 2, 3 and 4.
- SRC: fetches the source address at word 6+2k for each source k.
- RD: reads one data word from each source.
- WR: writes one destination word.
- STAT: writes the status word.
- DONE: one cycle for the event pulses.
- END: idle after the end of a chain.
- RELINK: re-reads the link word of the last descriptor.

Its transitions are:
- IDLE→LINK on `start`.
- LINK→CTRL→PAT→LEN→DST, each on a response.
- DST→SRC for XOR, copy or check.
- DST→WR for a fill.
- DST→STAT or DONE when the length is zero.
- SRC→RD after the last source address, or SRC→STAT/DONE when the length is zero.
- RD→RD on to the next word in check mode.
- RD→WR after the last source of a word, otherwise.
- WR→RD or WR→WR for the next word.
- RD, WR or SRC→STAT when write-back is enabled and the work is done, otherwise to DONE.
- STAT→DONE.
- DONE→LINK for a nonzero link, DONE→END for a zero link.
- END→LINK on `start`.
- END→RELINK on `resume`.
- RELINK→LINK when the re-read link is nonzero, RELINK→END when it is zero.

Top module: `xor_chain_engine`

## Requirements
- R1: A descriptor's word 0 is the link to the next descriptor. After each descriptor `eot` pulses for exactly one cycle. When the link is zero, `eoc` pulses in the same cycle as that last `eot`, and `busy` is low from the next cycle on.
- R2: The control word is descriptor word 1:
  - bit 0 requests an interrupt;
  - bits 6:3 give the number of sources minus one;
  - bit 7 selects zero-check;
  - bit 8 selects fill;
  - bit 12 enables status write-back;
  - bits 2:1 (direction) have no effect.
- R3: Without fill or zero-check, destination word i (base address at descriptor word 4) becomes the XOR of word i of every source. Source k's address is at descriptor word 6+2k. The number of words is bits 23:0 of descriptor word 3 divided by 4. All 16 sources can be used.
- R4: With fill set, every destination word receives the 32-bit pattern from descriptor word 2, and no source is read.
- R5: With zero-check set, nothing is written to the destination. The zero-result error is set when any XOR word of the sources is nonzero.
- R6: With write-back enabled, descriptor word 3 is rewritten after the data phase. The status word has bit 31 = 1, bit 30 = zero-result error, bits 29:24 = 0, and bits 23:0 = the original length. Without write-back, word 3 is never written.
- R7: A descriptor with length zero makes no data access. It only performs its descriptor fetches and its optional status write, and then completes.
- R8: `irq` pulses together with `eot` exactly when control bit 0 of that descriptor is set.
- R9: In END, a `resume` pulse re-reads word 0 of the last descriptor. If that word is nonzero, the chain continues at that address. Otherwise the engine returns to END with no event.
- R10: At most one memory request is outstanding: after `mem_req`, no new request is made until `mem_rsp`. Requests happen only while `busy` is high.
- R11: After reset the engine is idle: `busy`, `mem_req`, `eot`, `eoc` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a chain at `head_addr` (IDLE or END) |
| head_addr | input | AW | Word address of the first descriptor |
| resume | input | 1 | In END, re-read the last link word |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rsp | input | 1 | Response to the outstanding request |
| mem_rdata | input | 32 | Read data, valid with `mem_rsp` |
| busy | output | 1 | High outside IDLE and END |
| eot | output | 1 | End-of-descriptor pulse |
| eoc | output | 1 | End-of-chain pulse |
| irq | output | 1 | Interrupt pulse for descriptors that request it |

## Verification
The bound checker watches the port protocol on every cycle:
- a single outstanding request, and requests only while busy;
- the event pulses are one cycle long;
- `eoc` and `irq` appear only together with `eot`;
- busy drops after the end of the chain.

Only the bench scenarios can show the data results. A scoreboard predicts every memory write: the XOR and copy results, fill patterns, status words and their error bit, and the order of those writes. The scenarios also show:
- the absence of destination writes in check mode;
- the number of accesses for a zero-length descriptor;
- both outcomes of a resume from END.

// File: rtl/xce_pkg.sv
package xce_pkg;
    localparam int SRC_MAX = 16;
    localparam int SEL_W   = 4;
    localparam int LEN_W   = 24;
    localparam int WCNT_W  = LEN_W - 2;

    localparam int CB_IRQ  = 0;
    localparam int CB_SEL  = 3;
    localparam int CB_ZCHK = 7;
    localparam int CB_FILL = 8;
    localparam int CB_WB   = 12;

    localparam int OFF_CTRL = 1;
    localparam int OFF_PAT  = 2;
    localparam int OFF_LEN  = 3;
    localparam int OFF_DST  = 4;
    localparam int OFF_SRC  = 6;

    typedef enum logic [3:0] {
        S_IDLE, S_LINK, S_CTRL, S_PAT, S_LEN, S_DST, S_SRC,
        S_RD, S_WR, S_STAT, S_DONE, S_END, S_RELINK
    } xce_state_e;
endpackage

// File: rtl/xce_src_table.sv
module xce_src_table #(
    parameter int AW  = 16,
    parameter int NUM = 16,
    localparam int IW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_addr,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_addr
);
    logic [AW-1:0] slot_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && wr_idx == IW'(g))
                slot_q[g] <= wr_addr;
        end
    end

    assign rd_addr = slot_q[rd_idx];
endmodule

// File: rtl/xce_accum.sv
module xce_accum #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          first,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] acc_q,
    output logic [DW-1:0] acc_nx
);
    assign acc_nx = first ? din : (acc_q ^ din);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (en)
            acc_q <= acc_nx;
    end
endmodule

// File: rtl/xor_chain_engine.sv
module xor_chain_engine
    import xce_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] head_addr,
    input  logic          resume,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_rsp,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic          eot,
    output logic          eoc,
    output logic          irq
);
    xce_state_e state_q, state_nx;

    logic              pend_q;
    logic [AW-1:0]     cur_q, link_q, dst_q;
    logic              link_nz_q;
    logic              irq_en_q, zchk_q, fill_q, wb_q;
    logic [SEL_W-1:0]  sel_q, k_q;
    logic [31:0]       pat_q;
    logic [LEN_W-1:0]  len_q;
    logic [WCNT_W-1:0] widx_q;
    logic              perr_q;

    logic [AW-1:0]     src_addr;
    logic [31:0]       acc_q, acc_nx;

    wire [WCNT_W-1:0] nwords   = len_q[LEN_W-1:2];
    wire              zero_len = (nwords == '0);
    wire              last_w   = (widx_q + 1'b1 == nwords);
    wire              last_k   = (k_q == sel_q);
    wire              rd_nz    = (mem_rdata != '0);
    wire xce_state_e  fin_st   = wb_q ? S_STAT : S_DONE;

    xce_src_table #(.AW(AW), .NUM(SRC_MAX)) src_tab_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (state_q == S_SRC && mem_rsp),
        .wr_idx  (k_q),
        .wr_addr (mem_rdata[AW-1:0]),
        .rd_idx  (k_q),
        .rd_addr (src_addr)
    );

    xce_accum #(.DW(32)) accum_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state_q == S_RD && mem_rsp),
        .first  (k_q == '0),
        .din    (mem_rdata),
        .acc_q  (acc_q),
        .acc_nx (acc_nx)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_nx = S_LINK;
            S_LINK:   if (mem_rsp) state_nx = S_CTRL;
            S_CTRL:   if (mem_rsp) state_nx = S_PAT;
            S_PAT:    if (mem_rsp) state_nx = S_LEN;
            S_LEN:    if (mem_rsp) state_nx = S_DST;
            S_DST:    if (mem_rsp) begin
                          if (fill_q) state_nx = zero_len ? fin_st : S_WR;
                          else        state_nx = S_SRC;
                      end
            S_SRC:    if (mem_rsp && last_k) state_nx = zero_len ? fin_st : S_RD;
            S_RD:     if (mem_rsp && last_k) begin
                          if (zchk_q) state_nx = last_w ? fin_st : S_RD;
                          else        state_nx = S_WR;
                      end
            S_WR:     if (mem_rsp) state_nx = last_w ? fin_st : (fill_q ? S_WR : S_RD);
            S_STAT:   if (mem_rsp) state_nx = S_DONE;
            S_DONE:   state_nx = link_nz_q ? S_LINK : S_END;
            S_END:    if (start) state_nx = S_LINK;
                      else if (resume) state_nx = S_RELINK;
            S_RELINK: if (mem_rsp) state_nx = rd_nz ? S_LINK : S_END;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            cur_q     <= '0;
            link_q    <= '0;
            link_nz_q <= 1'b0;
            dst_q     <= '0;
            irq_en_q  <= 1'b0;
            zchk_q    <= 1'b0;
            fill_q    <= 1'b0;
            wb_q      <= 1'b0;
            sel_q     <= '0;
            k_q       <= '0;
            pat_q     <= '0;
            len_q     <= '0;
            widx_q    <= '0;
            perr_q    <= 1'b0;
        end else begin
            if (mem_req)      pend_q <= 1'b1;
            else if (mem_rsp) pend_q <= 1'b0;

            if ((state_q == S_IDLE || state_q == S_END) && start)
                cur_q <= head_addr;
            if (state_q == S_DONE && link_nz_q)
                cur_q <= link_q;

            if (mem_rsp) begin
                unique case (state_q)
                    S_LINK: begin
                        link_q    <= mem_rdata[AW-1:0];
                        link_nz_q <= rd_nz;
                    end
                    S_CTRL: begin
                        irq_en_q <= mem_rdata[CB_IRQ];
                        sel_q    <= mem_rdata[CB_SEL +: SEL_W];
                        zchk_q   <= mem_rdata[CB_ZCHK];
                        fill_q   <= mem_rdata[CB_FILL];
                        wb_q     <= mem_rdata[CB_WB];
                    end
                    S_PAT: pat_q <= mem_rdata;
                    S_LEN: begin
                        len_q  <= mem_rdata[LEN_W-1:0];
                        perr_q <= 1'b0;
                        widx_q <= '0;
                        k_q    <= '0;
                    end
                    S_DST: dst_q <= mem_rdata[AW-1:0];
                    S_SRC: k_q <= last_k ? '0 : k_q + 1'b1;
                    S_RD: begin
                        k_q <= last_k ? '0 : k_q + 1'b1;
                        if (last_k && zchk_q) begin
                            perr_q <= perr_q | (acc_nx != '0);
                            widx_q <= widx_q + 1'b1;
                        end
                    end
                    S_WR: widx_q <= widx_q + 1'b1;
                    S_RELINK: if (rd_nz) cur_q <= mem_rdata[AW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        unique case (state_q)
            S_LINK, S_RELINK: mem_req = !pend_q;
            S_CTRL: begin mem_req = !pend_q; mem_addr = cur_q + AW'(OFF_CTRL); end
            S_PAT:  begin mem_req = !pend_q; mem_addr = cur_q + AW'(OFF_PAT);  end
            S_LEN:  begin mem_req = !pend_q; mem_addr = cur_q + AW'(OFF_LEN);  end
            S_DST:  begin mem_req = !pend_q; mem_addr = cur_q + AW'(OFF_DST);  end
            S_SRC: begin
                mem_req  = !pend_q;
                mem_addr = cur_q + AW'(OFF_SRC) + AW'({k_q, 1'b0});
            end
            S_RD: begin
                mem_req  = !pend_q;
                mem_addr = src_addr + AW'(widx_q);
            end
            S_WR: begin
                mem_req   = !pend_q;
                mem_we    = 1'b1;
                mem_addr  = dst_q + AW'(widx_q);
                mem_wdata = fill_q ? pat_q : acc_q;
            end
            S_STAT: begin
                mem_req   = !pend_q;
                mem_we    = 1'b1;
                mem_addr  = cur_q + AW'(OFF_LEN);
                mem_wdata = {1'b1, perr_q, 6'b0, len_q};
            end
            default: ;
        endcase
        busy = !(state_q == S_IDLE || state_q == S_END);
        eot  = (state_q == S_DONE);
        eoc  = (state_q == S_DONE) && !link_nz_q;
        irq  = (state_q == S_DONE) && irq_en_q;
    end
endmodule

// File: rtl/xce_chk.sv
module xce_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_req,
    input logic mem_rsp,
    input logic busy,
    input logic eot,
    input logic eoc,
    input logic irq
);
    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R10
    req_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    // R10
    rsp_not_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp |-> !mem_req);
    // R1
    eoc_with_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> eot);
    // R1
    idle_after_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !busy);
    // R1
    eot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot |=> !eot);
    // R8
    irq_with_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> eot);
endmodule

bind xor_chain_engine xce_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_req (mem_req),
    .mem_rsp (mem_rsp),
    .busy    (busy),
    .eot     (eot),
    .eoc     (eoc),
    .irq     (irq)
);

// File: tb/xor_chain_engine_tb_top.sv
`timescale 1ns/1ps
module xor_chain_engine_tb_top;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] head_addr = '0;
    logic resume = 1'b0;
    logic mem_req, mem_we, mem_rsp;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic busy, eot, eoc, irq;

    always #10 clk = ~clk;

    xor_chain_engine #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .head_addr(head_addr),
        .resume(resume), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp(mem_rsp),
        .mem_rdata(mem_rdata), .busy(busy), .eot(eot), .eoc(eoc), .irq(irq)
    );

    logic [31:0] mem [0:2047];
    logic        pk_en = 1'b0;
    logic [10:0] pk_a = '0;
    logic [31:0] pk_d = '0;

    always @(posedge clk) begin
        mem_rsp <= rst_n && mem_req;
        if (pk_en) mem[pk_a] <= pk_d;
        else if (mem_req && mem_we) mem[mem_addr[10:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[10:0]];
    end

    int tot = 0, nfail = 0;
    int eot_cnt = 0, eoc_cnt = 0, irq_cnt = 0, req_cnt = 0;
    logic [47:0] expq [$];

    task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        tot++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected writes and counts events
    always @(negedge clk) begin
        if (rst_n) begin
            if (eot) eot_cnt++;
            if (eoc) eoc_cnt++;
            if (irq) irq_cnt++;
            if (mem_req) req_cnt++;
            if (mem_req && mem_we) begin
                if (expq.size() == 0)
                    check(1'b0, "R3/R4/R5/R6 unexpected write", {mem_addr, mem_wdata}, 48'h0);
                else begin
                    logic [47:0] e;
                    e = expq.pop_front();
                    check({mem_addr, mem_wdata} == e, "R3/R4/R6 write", {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    function automatic logic [31:0] sval(int r, int i);
        int q = (r == 15) ? 14 : r;
        return {8'(q + 17), 8'h5A, 8'(i), 8'(q * 7 + i * 3)};
    endfunction

    function automatic int raddr(int r);
        return 'h100 + 16 * r;
    endfunction

    function automatic logic [31:0] mkctrl(bit ie, int nsrc, bit zc, bit fl, bit wb);
        return 32'(ie) | (32'd3 << 1) | (32'(nsrc - 1) << 3) | (32'(zc) << 7)
             | (32'(fl) << 8) | (32'(wb) << 12);
    endfunction

    task automatic poke(input int a, input logic [31:0] d);
        @(negedge clk);
        pk_en = 1'b1; pk_a = 11'(a); pk_d = d;
        @(posedge clk);
        #1 pk_en = 1'b0;
    endtask

    task automatic put_desc(input int a, input int link, input logic [31:0] ctrl,
                            input logic [31:0] pat, input int len, input int dst,
                            input int nsrc, input int s0);
        poke(a, 32'(link));
        poke(a + 1, ctrl);
        poke(a + 2, pat);
        poke(a + 3, 32'(len));
        poke(a + 4, 32'(dst));
        poke(a + 5, 32'hFFFF_FFFF);
        for (int k = 0; k < nsrc; k++) begin
            poke(a + 6 + 2 * k, 32'(raddr((s0 + k) % 16)));
            poke(a + 7 + 2 * k, 32'hDEAD_0000);
        end
    endtask

    task automatic expect_desc(input int a, input bit zc, input bit fl, input bit wb,
                               input logic [31:0] pat, input int len, input int dst,
                               input int nsrc, input int s0);
        bit perr = 1'b0;
        int nw = len / 4;
        for (int i = 0; i < nw; i++) begin
            logic [31:0] x;
            if (fl) x = pat;
            else begin
                x = '0;
                for (int k = 0; k < nsrc; k++) x ^= sval((s0 + k) % 16, i);
            end
            if (zc) perr |= (x != 0);
            else expq.push_back({16'(dst + i), x});
        end
        if (wb) expq.push_back({16'(a + 3), {1'b1, perr, 6'b0, 24'(len)}});
    endtask

    task automatic run_chain(input int head, input bit via_resume);
        int e0 = eoc_cnt;
        @(negedge clk);
        if (via_resume) resume = 1'b1;
        else begin start = 1'b1; head_addr = 16'(head); end
        @(negedge clk);
        start = 1'b0; resume = 1'b0;
        for (int c = 0; c < 20000 && eoc_cnt == e0; c++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++; tot++;
        $display("FAIL watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", tot - nfail, tot);
        $finish;
    end

    initial begin
        int e0, i0, r0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !mem_req && !eot && !eoc && !irq, "R11 reset idle",
              {43'b0, busy, mem_req, eot, eoc, irq}, 48'h0);
        rst_n = 1'b1;
        for (int r = 0; r < 16; r++)
            for (int i = 0; i < 16; i++) poke(raddr(r) + i, sval(r, i));

        // chain: copy(wb) -> XOR3(no wb) -> fill(wb, irq)   R1 R2 R3 R4 R6 R8
        put_desc('h040, 'h080, mkctrl(0, 1, 0, 0, 1), 32'h0, 12, 'h300, 1, 2);
        put_desc('h080, 'h0C0, mkctrl(0, 3, 0, 0, 0), 32'h0, 8,  'h310, 3, 4);
        put_desc('h0C0, 0,     mkctrl(1, 1, 0, 1, 1), 32'hCAFE_F00D, 16, 'h320, 1, 0);
        expect_desc('h040, 0, 0, 1, 0, 12, 'h300, 1, 2);
        expect_desc('h080, 0, 0, 0, 0, 8,  'h310, 3, 4);
        expect_desc('h0C0, 0, 1, 1, 32'hCAFE_F00D, 16, 'h320, 1, 0);
        e0 = eot_cnt; i0 = irq_cnt;
        run_chain('h040, 0);
        check(eot_cnt - e0 == 3, "R1 eot per descriptor", 48'(eot_cnt - e0), 48'd3);
        check(irq_cnt - i0 == 1, "R8 irq only on enabled", 48'(irq_cnt - i0), 48'd1);
        check(!busy, "R1 busy low after chain", 48'(busy), 48'h0);
        check(expq.size() == 0, "R3 R4 all writes seen", 48'(expq.size()), 48'h0);
        check(mem['h083] == 32'd8, "R6 no write-back when disabled", 48'(mem['h083]), 48'd8);

        // zero-check: equal sources then differing sources   R5 R6
        poke('h380, 32'hDEAD_BEEF);
        put_desc('h400, 'h440, mkctrl(0, 2, 1, 0, 1), 32'h0, 16, 'h380, 2, 14);
        put_desc('h440, 0,     mkctrl(0, 2, 1, 0, 1), 32'h0, 8,  'h380, 2, 0);
        expect_desc('h400, 1, 0, 1, 0, 16, 'h380, 2, 14);
        expect_desc('h440, 1, 0, 1, 0, 8,  'h380, 2, 0);
        run_chain('h400, 0);
        check(mem['h403] == 32'h8000_0010, "R5 zero result clean", 48'(mem['h403]), 48'h8000_0010);
        check(mem['h443] == 32'hC000_0008, "R5 zero result error", 48'(mem['h443]), 48'hC000_0008);
        check(mem['h380] == 32'hDEAD_BEEF, "R5 destination untouched", 48'(mem['h380]), 48'hDEAD_BEEF);
        check(expq.size() == 0, "R5 writes seen", 48'(expq.size()), 48'h0);

        // zero-length interrupt-only descriptor   R7 R8
        put_desc('h480, 0, mkctrl(1, 1, 0, 0, 1), 32'h0, 0, 'h390, 1, 0);
        expect_desc('h480, 0, 0, 1, 0, 0, 'h390, 1, 0);
        i0 = irq_cnt; r0 = req_cnt;
        run_chain('h480, 0);
        check(req_cnt - r0 == 7, "R7 only fetches and status", 48'(req_cnt - r0), 48'd7);
        check(irq_cnt - i0 == 1, "R8 irq on zero length", 48'(irq_cnt - i0), 48'd1);
        check(mem['h483] == 32'h8000_0000, "R7 completes", 48'(mem['h483]), 48'h8000_0000);

        // sixteen sources   R2 R3
        put_desc('h4C0, 0, mkctrl(0, 16, 0, 0, 0), 32'h0, 4, 'h3A0, 16, 0);
        expect_desc('h4C0, 0, 0, 0, 0, 4, 'h3A0, 16, 0);
        run_chain('h4C0, 0);
        check(expq.size() == 0, "R3 sixteen sources", 48'(expq.size()), 48'h0);

        // resume with zero link, then after linking   R9
        e0 = eot_cnt;
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
        repeat (10) @(negedge clk);
        check(eot_cnt == e0 && !busy, "R9 resume on zero link stays idle",
              48'(eot_cnt - e0), 48'h0);
        put_desc('h500, 0, mkctrl(0, 1, 0, 1, 1), 32'h1234_5678, 8, 'h3B0, 1, 0);
        poke('h4C0, 32'h500);
        expect_desc('h500, 0, 1, 1, 32'h1234_5678, 8, 'h3B0, 1, 0);
        run_chain(0, 1);
        check(eot_cnt - e0 == 1, "R9 resume continues", 48'(eot_cnt - e0), 48'd1);
        check(expq.size() == 0, "R9 resumed writes seen", 48'(expq.size()), 48'h0);

        $display("%0d/%0d checks passed", tot - nfail, tot);
        $finish;
    end
endmodule